// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every memory access a core issues, whether that access may proceed. It takes the physical address of the access, the access kind (read, write or instruction fetch), whether the core is in machine mode or a lower privilege mode, and the configuration byte and address word of every protection entry. It returns one permit or fault bit per access. The configuration and address values come straight from the storage that holds them elsewhere; this block only evaluates them.

Each entry covers a region in one of three ways. A top-of-range entry spans from the previous entry's address word up to its own. A single-word entry covers exactly one 4-byte unit. A power-of-two entry covers an aligned block whose size is encoded in the trailing ones of its address word. An entry can also be switched off. When several entries cover an address, the lowest-numbered one decides. Its lock bit chooses whether machine mode must also obey its permissions. The decision logic is purely combinational. A parameter selects whether the result is registered, which is the default, or passed straight through.

Top module: `pmp_checker`

## Requirements
- R1: Configuration byte fields: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 select the match mode (0 off, 1 top-of-range, 2 single word, 3 power-of-two), bit 7 is the lock, and bits 6:5 are held at zero. Access kind code 0 is read, 1 is write, 2 is execute.
- R2: An entry whose mode is off never matches, but its address word still serves as the lower bound of the entry above it.
- R3: A top-of-range entry matches word addresses w with lower <= w < upper. The upper bound is its own address word. The lower bound is the previous entry's address word, or zero for entry 0. If lower >= upper, the entry matches nothing.
- R4: A single-word entry matches only the one word address equal to its address word.
- R5: A power-of-two entry whose address word has t trailing ones covers 2^(t+1) words, aligned to that size. An all-ones address word covers the whole address space.
- R6: When several entries match, the lowest-numbered one decides, even if a higher entry would give a different answer.
- R7: When the deciding entry is unlocked, a machine-mode access is permitted whatever its permission bits say. A lower-mode access is permitted only if the bit for its kind is set.
- R8: When the deciding entry is locked, machine-mode accesses are also permitted only if the bit for their kind is set.
- R9: If no entry matches, a machine-mode access is permitted. A lower-mode access is denied when at least one entry is not off, and permitted when all entries are off.
- R10: With the output register enabled (the default), res_valid and res_permit appear on the clock edge after acc_valid is sampled. res_valid is low after a cycle with acc_valid low. A synchronous reset drives both outputs to 0.
- R11: Address bits 1:0 have no effect on the result; matching is done on 4-byte word addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | PA_WIDTH | Physical byte address of the access |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| acc_machine | input | 1 | 1 when the access is made in machine mode |
| ent_cfg | input | NUM_ENTRIES*8 | Configuration bytes, entry i at bits 8i+7:8i |
| ent_addr | input | NUM_ENTRIES*(PA_WIDTH-2) | Address words (byte address >> 2), entry i at slice i |
| res_valid | output | 1 | Result valid |
| res_permit | output | 1 | 1 permits the access, 0 faults it |

## Verification
The assertions assume that reserved configuration bits 6:5 are zero and that the access kind is one of the three defined codes. The stimulus writes only configuration bytes built from the defined fields and drives kind codes 0 to 2. The stimulus holds entry values steady while an access is in flight, so each registered result depends only on what was presented the cycle before. Table vectors cover overlapping regions, empty ranges and sub-word offsets without breaking these limits. The directed tests change the configuration only between accesses.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_WORD  = 2'd2,
    MODE_POW2  = 2'd3
  } match_mode_e;

  // Field order follows the bit positions the register storage uses.
  typedef struct packed {
    logic        lock;
    logic [1:0]  rsv;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } ent_cfg_t;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cfg_byte,
  input  logic [AW-1:0] lo_word,
  input  logic [AW-1:0] hi_word,
  input  logic [AW-1:0] acc_word,
  input  logic [1:0]    acc_kind,
  output logic          hit,
  output logic          grant,
  output logic          locked,
  output logic          active
);

  ent_cfg_t      cfg;
  logic [AW-1:0] dont_care;
  logic          tor_hit;
  logic          word_hit;
  logic          pow2_hit;

  assign cfg = ent_cfg_t'(cfg_byte);

  // Trailing ones of the address word plus the next bit mark the free bits.
  assign dont_care = hi_word ^ (hi_word + 1'b1);
  assign pow2_hit  = ((acc_word ^ hi_word) & ~dont_care) == '0;
  assign tor_hit   = (acc_word >= lo_word) && (acc_word < hi_word);
  assign word_hit  = (acc_word == hi_word);

  always_comb begin
    unique case (cfg.mode)
      MODE_TOR:  hit = tor_hit;
      MODE_WORD: hit = word_hit;
      MODE_POW2: hit = pow2_hit;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (acc_kind)
      KIND_READ:  grant = cfg.r;
      KIND_WRITE: grant = cfg.w;
      KIND_EXEC:  grant = cfg.x;
      default:    grant = 1'b0;
    endcase
  end

  assign locked = cfg.lock;
  assign active = (cfg.mode != MODE_OFF);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_byte[6:5] == 2'b00);                                        // R1
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (cfg_byte[4:3] == 2'd0) |-> !hit);                              // R2
  AST_TOR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cfg_byte[4:3] == 2'd1 && lo_word >= hi_word) |-> !hit);        // R3
  AST_WORD_EXACT: assert property (@(posedge clk) disable iff (rst)
    (cfg_byte[4:3] == 2'd2 && hit) |-> (acc_word == hi_word));      // R4

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit_vec,
  input  logic [N-1:0] grant_vec,
  input  logic [N-1:0] lock_vec,
  output logic         any_hit,
  output logic         sel_grant,
  output logic         sel_lock
);

  int unsigned sel_idx;

  // Walk from the top so the lowest matching index is written last.
  always_comb begin
    any_hit   = 1'b0;
    sel_grant = 1'b0;
    sel_lock  = 1'b0;
    sel_idx   = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit   = 1'b1;
        sel_grant = grant_vec[i];
        sel_lock  = lock_vec[i];
        sel_idx   = i;
      end
    end
  end

  AST_FIRST_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit_vec[sel_idx] &&
                 ((hit_vec & ((N'(1) << sel_idx) - N'(1))) == '0)));  // R6

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_WIDTH    = 34,
  parameter bit OUT_REG     = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  acc_valid,
  input  logic [PA_WIDTH-1:0]                   acc_addr,
  input  logic [1:0]                            acc_kind,
  input  logic                                  acc_machine,
  input  logic [NUM_ENTRIES*8-1:0]              ent_cfg,
  input  logic [NUM_ENTRIES*(PA_WIDTH-2)-1:0]   ent_addr,
  output logic                                  res_valid,
  output logic                                  res_permit
);

  localparam int AW = PA_WIDTH - 2;

  logic [AW-1:0]          acc_word;
  logic [AW-1:0]          lo_b [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] grant_vec;
  logic [NUM_ENTRIES-1:0] lock_vec;
  logic [NUM_ENTRIES-1:0] active_vec;
  logic                   any_hit;
  logic                   sel_grant;
  logic                   sel_lock;
  logic                   comb_permit;

  assign acc_word = acc_addr[PA_WIDTH-1:2];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    if (g == 0) begin : g_base
      assign lo_b[g] = '0;
    end else begin : g_chain
      assign lo_b[g] = ent_addr[(g-1)*AW +: AW];
    end

    pmp_region_match #(.AW(AW)) i_match (
      .clk      (clk),
      .rst      (rst),
      .cfg_byte (ent_cfg[g*8 +: 8]),
      .lo_word  (lo_b[g]),
      .hi_word  (ent_addr[g*AW +: AW]),
      .acc_word (acc_word),
      .acc_kind (acc_kind),
      .hit      (hit_vec[g]),
      .grant    (grant_vec[g]),
      .locked   (lock_vec[g]),
      .active   (active_vec[g])
    );
  end

  pmp_first_hit #(.N(NUM_ENTRIES)) i_first (
    .clk       (clk),
    .rst       (rst),
    .hit_vec   (hit_vec),
    .grant_vec (grant_vec),
    .lock_vec  (lock_vec),
    .any_hit   (any_hit),
    .sel_grant (sel_grant),
    .sel_lock  (sel_lock)
  );

  always_comb begin
    if (any_hit)
      comb_permit = sel_grant || (acc_machine && !sel_lock);
    else
      comb_permit = acc_machine || !(|active_vec);
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_valid  <= 1'b0;
        res_permit <= 1'b0;
      end else begin
        res_valid  <= acc_valid;
        res_permit <= acc_valid && comb_permit;
      end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> res_valid);                                     // R10
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |=> !res_valid);                                   // R10
  end else begin : g_pass
    assign res_valid  = acc_valid;
    assign res_permit = acc_valid && comb_permit;
  end

  AST_MACHINE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_machine && !(|lock_vec)) |-> comb_permit);    // R7
  AST_QUIET_ALLOW: assert property (@(posedge clk) disable iff (rst)
    !(|active_vec) |-> comb_permit);                                // R9
  AST_OFFSET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (acc_addr[PA_WIDTH-1:2] == $past(acc_addr[PA_WIDTH-1:2]) &&
     acc_addr[1:0] != $past(acc_addr[1:0]) &&
     $stable(acc_kind) && $stable(acc_machine) &&
     $stable(ent_cfg) && $stable(ent_addr))
    |-> (comb_permit == $past(comb_permit)));                       // R11

endmodule

// File: tb/test_pmp_checker.sv
`timescale 1ns/1ps
module test_pmp_checker;

  localparam int N  = 16;
  localparam int PA = 34;
  localparam int AW = PA - 2;
  localparam int NV = 22;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_valid;
  logic [PA-1:0]     acc_addr;
  logic [1:0]        acc_kind;
  logic              acc_machine;
  logic [N*8-1:0]    ent_cfg;
  logic [N*AW-1:0]   ent_addr;
  logic              res_valid;
  logic              res_permit;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pmp_checker #(.NUM_ENTRIES(N), .PA_WIDTH(PA), .OUT_REG(1'b1)) i_pmp_checker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_machine(acc_machine), .ent_cfg(ent_cfg),
    .ent_addr(ent_addr), .res_valid(res_valid), .res_permit(res_permit)
  );

  // {req[3:0], byte address[33:0], kind[1:0], machine, expected permit}
  // Table config: e0 TOR RW to 0x400; e1 word R at 0x800; e2 pow2 X 0x1000+0x100;
  // e3 locked pow2 R 0x1000+0x1000; e4 locked TOR RW words 0x5FF..0x9FF; e5 empty TOR.
  localparam logic [41:0] VECS [NV] = '{
    {4'd3,  34'h0000_0000, 2'd0, 1'b0, 1'b1},  // R3 R1 entry0 lower bound zero
    {4'd3,  34'h0000_03FC, 2'd1, 1'b0, 1'b1},  // R3 last word of range
    {4'd1,  34'h0000_03FC, 2'd2, 1'b0, 1'b0},  // R1 no execute bit
    {4'd9,  34'h0000_0400, 2'd0, 1'b0, 1'b0},  // R9 upper bound excluded, lower deny
    {4'd9,  34'h0000_0400, 2'd0, 1'b1, 1'b1},  // R9 machine allowed on miss
    {4'd4,  34'h0000_0800, 2'd0, 1'b0, 1'b1},  // R4 single word hit
    {4'd4,  34'h0000_0800, 2'd1, 1'b0, 1'b0},  // R4 write not granted
    {4'd4,  34'h0000_0804, 2'd0, 1'b0, 1'b0},  // R4 next word misses
    {4'd5,  34'h0000_1000, 2'd2, 1'b0, 1'b1},  // R5 pow2 base
    {4'd5,  34'h0000_10FC, 2'd2, 1'b0, 1'b1},  // R5 pow2 last word
    {4'd6,  34'h0000_1100, 2'd2, 1'b0, 1'b0},  // R6 falls to entry3
    {4'd5,  34'h0000_1100, 2'd0, 1'b0, 1'b1},  // R5 entry3 read
    {4'd8,  34'h0000_1100, 2'd2, 1'b1, 1'b0},  // R8 locked binds machine
    {4'd7,  34'h0000_1000, 2'd0, 1'b1, 1'b1},  // R7 unlocked frees machine
    {4'd6,  34'h0000_1000, 2'd0, 1'b0, 1'b0},  // R6 entry2 beats entry3
    {4'd11, 34'h0000_1802, 2'd1, 1'b1, 1'b0},  // R11 offset ignored, R8 locked
    {4'd11, 34'h0000_1803, 2'd2, 1'b0, 1'b0},  // R11 offset ignored
    {4'd3,  34'h0000_2000, 2'd1, 1'b1, 1'b1},  // R3 lower from pow2 neighbour
    {4'd8,  34'h0000_2000, 2'd2, 1'b1, 1'b0},  // R8 locked TOR execute
    {4'd3,  34'h0000_27FC, 2'd0, 1'b0, 1'b1},  // R3 top word of entry4
    {4'd3,  34'h0000_2800, 2'd0, 1'b0, 1'b0},  // R3 empty entry5 never hits
    {4'd1,  34'h0000_2400, 2'd2, 1'b0, 1'b0}   // R1 execute bit clear
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic clear_cfg();
    ent_cfg  = '0;
    ent_addr = '0;
  endtask

  task automatic set_ent(input int idx, input logic [7:0] c, input logic [AW-1:0] a);
    ent_cfg[idx*8 +: 8]   = c;
    ent_addr[idx*AW +: AW] = a;
  endtask

  // Drive at a falling edge, registered result is sampled at the next one.
  task automatic probe(input string tag, input logic [PA-1:0] a, input logic [1:0] k,
                       input logic m, input logic exp);
    acc_valid   = 1'b1;
    acc_addr    = a;
    acc_kind    = k;
    acc_machine = m;
    @(negedge clk);
    check({tag, " valid"}, res_valid, 1'b1);
    check(tag, res_permit, exp);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R10 watchdog: got hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b1; acc_addr = '0; acc_kind = 2'd0; acc_machine = 1'b1;
    clear_cfg();
    repeat (3) @(negedge clk);
    check("R10 reset valid", res_valid, 1'b0);
    check("R10 reset permit", res_permit, 1'b0);
    rst = 1'b0;
    acc_valid = 1'b0;
    @(negedge clk);
    check("R10 idle valid", res_valid, 1'b0);

    // R9 all entries off: lower mode permitted
    probe("R9 all off", 34'h0_0000_1234 & ~34'h3, 2'd1, 1'b0, 1'b1);

    set_ent(0, 8'h0B, 32'h0000_0100);
    set_ent(1, 8'h11, 32'h0000_0200);
    set_ent(2, 8'h1C, 32'h0000_041F);
    set_ent(3, 8'h99, 32'h0000_05FF);
    set_ent(4, 8'h8B, 32'h0000_0A00);
    set_ent(5, 8'h0F, 32'h0000_0600);
    for (int v = 0; v < NV; v++) begin
      probe($sformatf("R%0d vector %0d", VECS[v][41:38], v),
            VECS[v][37:4], VECS[v][3:2], VECS[v][1], VECS[v][0]);
    end

    // R2 off entry supplies the lower bound to the TOR entry above it
    clear_cfg();
    set_ent(0, 8'h07, 32'h0000_0100);
    set_ent(1, 8'h0B, 32'h0000_0200);
    probe("R2 off entry no hit", 34'h0_0000_0200, 2'd0, 1'b0, 1'b0);
    probe("R2 bound from off entry", 34'h0_0000_0400, 2'd0, 1'b0, 1'b1);

    // R3 entry0 TOR spans from zero
    clear_cfg();
    set_ent(0, 8'h09, 32'h0000_0001);
    probe("R3 entry0 from zero", 34'h0_0000_0000, 2'd0, 1'b0, 1'b1);
    probe("R3 entry0 upper excluded", 34'h0_0000_0004, 2'd0, 1'b0, 1'b0);

    // R5 all-ones pow2 covers everything
    clear_cfg();
    set_ent(0, 8'h1A, 32'hFFFF_FFFF);
    probe("R5 all-ones top read", 34'h3_FFFF_FFFC, 2'd0, 1'b0, 1'b0);
    probe("R5 all-ones zero write", 34'h0_0000_0000, 2'd1, 1'b0, 1'b1);
    probe("R7 all-ones machine read", 34'h2_0000_0000, 2'd0, 1'b1, 1'b1);
    set_ent(0, 8'h9A, 32'hFFFF_FFFF);
    probe("R8 all-ones locked machine", 34'h2_0000_0000, 2'd0, 1'b1, 1'b0);

    acc_valid = 1'b0;
    @(negedge clk);
    check("R10 valid drops", res_valid, 1'b0);

    // R10 reset while an access is presented
    acc_valid = 1'b1; acc_machine = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset mid-run valid", res_valid, 1'b0);
    check("R10 reset mid-run permit", res_permit, 1'b0);
    rst = 1'b0;
    acc_valid = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule